// File: doc/BRIEF.md
# Serial Display Link Master

This block is the controller side of a serial link to a display panel. It turns each request into one framed access, carried on an active-low chip select and a serial clock that idles low. A frame holds up to four parts, in this order: an optional preamble, a short command field, one or more data words, and the final release of chip select. The preamble length and bit contents are programmable. The command field carries a read/write flag and a register-select flag. Their order can be swapped, and the read/write flag can be left out. A single request can move one word or a burst of words, and chip select stays low for the whole burst.

Four wiring modes are supported. In the 3-wire mode the block keeps its serial input and output apart internally. It drives an output-enable, and a pad mux outside the block uses it to merge the two onto one shared pin. The 4-wire mode uses separate data lines. In both of these modes register-select travels inside the serial stream. The two 5-wire modes take register-select out of the stream and put it on a pin of its own. That pin is driven in one of two ways: for the whole chip-select window, so that the panel can latch it on the chip-select edge, or only while data bits are clocked, so that it is sampled by the serial clock.

Requests use a valid/ready handshake, and `req_ready` is high only while the link is idle. Write words come in on a valid/ready stream. `wr_ready` rises for one cycle at each word boundary, and the word moves when `wr_valid` is high in that cycle. If no word is valid at a boundary, the frame waits with the serial clock low and chip select held. It resumes a full bit time later, once the word arrives. Read words go out as a one-cycle `rd_valid` strobe, and that side has no back-pressure. Configuration inputs must be held steady while `busy` is high.

Top module: `serdisp_master`

## Requirements
- R1: After reset and between frames: `ser_csn`=1, `ser_clk`=0, `ser_dout`=0, `ser_doe`=0, `ser_rs`=0, `busy`=0, `req_ready`=1 and `rd_valid`=0.
- R2: An accepted request pulls `ser_csn` low in the next cycle. A lead of two half-periods with the clock low comes before the first bit, and a trail of two half-periods with the clock low follows the last bit. Then `ser_csn` returns high. `busy` equals the inverse of `ser_csn`, and `req_ready` is high only while idle.
- R3: Every bit lasts H cycles with `ser_clk` low, then H cycles with it high. H is `cfg_half_div`, and the value 0 acts as 1. `ser_dout` changes only at bit boundaries, which are the falling edges.
- R4: The preamble sends `min(cfg_pre_len,16)` bits, from `cfg_pre_bits[len-1]` down to bit 0. A length of 0 sends no preamble.
- R5: In modes 0 (3-wire) and 1 (4-wire), the command field follows the preamble. When `cfg_rw_en`=1 it has two bits: read/write (1 = read) and register-select. `cfg_rs_first`=1 puts register-select first. When `cfg_rw_en`=0 only register-select is sent.
- R6: In modes 2 and 3 (5-wire), register-select is not in the stream. The command field is the single read/write bit when `cfg_rw_en`=1, and empty otherwise.
- R7: `ser_rs` carries the request's register-select as follows. In mode 3 it is driven for every cycle that `ser_csn` is low. In mode 2 it is driven only during data-phase bits. In modes 0 and 1 it stays 0.
- R8: A write sends `req_len`+1 words back to back, each most significant bit first, in the order taken from the write stream.
- R9: During read data bits, `ser_dout`=0 and `ser_doe`=0. `ser_din` is sampled at each rising clock edge, most significant bit first. Each word appears on `rd_data` with a one-cycle `rd_valid` in the cycle after its last bit's high half ends.
- R10: `ser_doe` is 1 for every cycle that `ser_csn` is low and no read data bit is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Wiring mode: 0 3-wire, 1 4-wire, 2 5-wire clock-sampled RS, 3 5-wire select-sampled RS |
| cfg_half_div | input | DIV_W | Serial clock half-period in system cycles (0 acts as 1) |
| cfg_pre_len | input | $clog2(PRE_MAX+1) | Preamble length in bits |
| cfg_pre_bits | input | PRE_MAX | Preamble contents, sent from bit len-1 down |
| cfg_rs_first | input | 1 | 1 sends register-select before read/write |
| cfg_rw_en | input | 1 | 1 includes the read/write bit |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_read | input | 1 | 1 read, 0 write |
| req_rs | input | 1 | Register-select value for the frame |
| req_len | input | LEN_W | Extra words in the burst (0 = single word) |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word taken this cycle when valid |
| wr_data | input | WORD_W | Write word |
| rd_valid | output | 1 | One-cycle strobe for a received word |
| rd_data | output | WORD_W | Received word |
| busy | output | 1 | Frame in progress |
| ser_csn | output | 1 | Chip select, active low |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_dout | output | 1 | Serial data out |
| ser_doe | output | 1 | Output enable for the shared-pin mux |
| ser_din | input | 1 | Serial data in |
| ser_rs | output | 1 | Register-select pin for the 5-wire modes |

## Verification
The bench covers a preamble of zero length, a length above the 16-bit ceiling, and a full-length pattern. An off-by-one in the preamble index or clamp would shift or truncate every later bit. Both command orders are run, with the read/write bit present and dropped, in the serial-RS and pin-RS modes. This catches a design that leaves register-select in the 5-wire stream or ignores the swap. Reads run in bursts while `ser_din` changes every bit. A design that samples on the falling edge, enables the driver during reception, or strobes `rd_valid` a cycle early or late would then show up against the cycle model. Half-periods of 0, 1, 2 and 3 show whether the divider stretches both halves equally and treats zero as one.

// File: rtl/serdisp_pkg.sv
package serdisp_pkg;
  typedef enum logic [1:0] {
    WIRE3     = 2'd0,
    WIRE4     = 2'd1,
    WIRE5_CLK = 2'd2,
    WIRE5_CS  = 2'd3
  } wire_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HDR,
    ST_DATA,
    ST_WAITW,
    ST_TRAIL
  } seq_state_e;
endpackage

// File: rtl/serdisp_halfclk.sv
module serdisp_halfclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  always_comb last = (half_div == '0) ? '0 : half_div - 1'b1;

  assign tick = run && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/serdisp_hdr.sv
module serdisp_hdr #(
  parameter int PRE_MAX = 16,
  localparam int PLW     = $clog2(PRE_MAX + 1),
  localparam int HDR_MAX = PRE_MAX + 2,
  localparam int HCW     = $clog2(HDR_MAX + 1)
) (
  input  logic [PLW-1:0]     pre_len,
  input  logic [PRE_MAX-1:0] pre_bits,
  input  logic               five_wire,
  input  logic               rs_first,
  input  logic               rw_en,
  input  logic               rd,
  input  logic               rs,
  output logic [HDR_MAX-1:0] vec,
  output logic [HCW-1:0]     len
);
  int         plen;
  int         ncmd;
  logic [1:0] cmd;

  always_comb begin
    plen = (int'(pre_len) > PRE_MAX) ? PRE_MAX : int'(pre_len);
    if (!five_wire) begin
      if (rw_en) begin
        ncmd = 2;
        cmd  = rs_first ? {rs, rd} : {rd, rs};
      end else begin
        ncmd = 1;
        cmd  = {rs, 1'b0};
      end
    end else begin
      ncmd = rw_en ? 1 : 0;
      cmd  = {rd, 1'b0};
    end
    vec = '0;
    for (int i = 0; i < HDR_MAX; i++) begin
      if (i < plen)
        vec[HDR_MAX-1-i] = pre_bits[plen-1-i];
      else if (i < plen + ncmd)
        vec[HDR_MAX-1-i] = cmd[1-(i-plen)];
    end
    len = HCW'(plen + ncmd);
  end
endmodule

// File: rtl/serdisp_rx.sv
module serdisp_rx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              din,
  input  logic              word_end,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= word_end;
      if (sample)   sr      <= {sr[WORD_W-2:0], din};
      if (word_end) rd_data <= sr;
    end
  end
endmodule

// File: rtl/serdisp_master.sv
module serdisp_master
  import serdisp_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int PRE_MAX = 16,
  parameter int DIV_W   = 8,
  parameter int LEN_W   = 4,
  localparam int PLW    = $clog2(PRE_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_mode,
  input  logic [DIV_W-1:0]   cfg_half_div,
  input  logic [PLW-1:0]     cfg_pre_len,
  input  logic [PRE_MAX-1:0] cfg_pre_bits,
  input  logic               cfg_rs_first,
  input  logic               cfg_rw_en,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_read,
  input  logic               req_rs,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [WORD_W-1:0]  wr_data,
  output logic               rd_valid,
  output logic [WORD_W-1:0]  rd_data,
  output logic               busy,
  output logic               ser_csn,
  output logic               ser_clk,
  output logic               ser_dout,
  output logic               ser_doe,
  input  logic               ser_din,
  output logic               ser_rs
);
  localparam int HDR_MAX = PRE_MAX + 2;
  localparam int HCW     = $clog2(HDR_MAX + 1);
  localparam int BCW     = $clog2(WORD_W + 1);

  seq_state_e         st;
  seq_state_e         data_st;
  wire_mode_e         mode_q;
  logic               ph;
  logic [HDR_MAX-1:0] hsr;
  logic [HDR_MAX-1:0] hdr_vec;
  logic [HCW-1:0]     hdr_len;
  logic [HCW-1:0]     hcnt;
  logic [WORD_W-1:0]  dsr;
  logic [BCW-1:0]     bcnt;
  logic [LEN_W-1:0]   wcnt;
  logic               is_rd;
  logic               rs_q;
  logic               run;
  logic               tick;
  logic               adv;
  logic               to_data;
  logic               load_slot;
  logic               sample;
  logic               word_end;

  serdisp_hdr #(.PRE_MAX(PRE_MAX)) u_hdr (
    .pre_len  (cfg_pre_len),
    .pre_bits (cfg_pre_bits),
    .five_wire(cfg_mode[1]),
    .rs_first (cfg_rs_first),
    .rw_en    (cfg_rw_en),
    .rd       (req_read),
    .rs       (req_rs),
    .vec      (hdr_vec),
    .len      (hdr_len)
  );

  assign run = (st == ST_LEAD) || (st == ST_HDR) || (st == ST_DATA) || (st == ST_TRAIL);

  serdisp_halfclk #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .half_div(cfg_half_div),
    .tick    (tick)
  );

  assign adv = tick && ph;

  always_comb begin
    to_data = ((st == ST_LEAD) && (hcnt == '0)) ||
              ((st == ST_HDR)  && (hcnt == HCW'(1))) ||
              ((st == ST_DATA) && (bcnt == BCW'(1)) && (wcnt != '0));
    data_st = (is_rd || wr_valid) ? ST_DATA : ST_WAITW;
  end

  assign load_slot = !is_rd && ((adv && to_data) || (st == ST_WAITW));
  assign wr_ready  = load_slot;
  assign sample    = tick && !ph && (st == ST_DATA) && is_rd;
  assign word_end  = adv && (st == ST_DATA) && (bcnt == BCW'(1)) && is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ph     <= 1'b0;
      hcnt   <= '0;
      bcnt   <= '0;
      wcnt   <= '0;
      is_rd  <= 1'b0;
      rs_q   <= 1'b0;
      mode_q <= WIRE3;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          st     <= ST_LEAD;
          ph     <= 1'b0;
          hcnt   <= hdr_len;
          wcnt   <= req_len;
          is_rd  <= req_read;
          rs_q   <= req_rs;
          mode_q <= wire_mode_e'(cfg_mode);
        end
        ST_WAITW: if (wr_valid) st <= ST_DATA;
        default: if (tick) begin
          ph <= !ph;
          if (ph) begin
            case (st)
              ST_LEAD: begin
                if (hcnt == '0) begin
                  st   <= data_st;
                  bcnt <= BCW'(WORD_W);
                end else begin
                  st <= ST_HDR;
                end
              end
              ST_HDR: begin
                hcnt <= hcnt - 1'b1;
                if (hcnt == HCW'(1)) begin
                  st   <= data_st;
                  bcnt <= BCW'(WORD_W);
                end
              end
              ST_DATA: begin
                if (bcnt == BCW'(1)) begin
                  if (wcnt == '0) begin
                    st <= ST_TRAIL;
                  end else begin
                    wcnt <= wcnt - 1'b1;
                    st   <= data_st;
                    bcnt <= BCW'(WORD_W);
                  end
                end else begin
                  bcnt <= bcnt - 1'b1;
                end
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsr <= '0;
      dsr <= '0;
    end else begin
      if ((st == ST_IDLE) && req_valid) hsr <= hdr_vec;
      else if (adv && (st == ST_HDR))   hsr <= {hsr[HDR_MAX-2:0], 1'b0};
      if (load_slot && wr_valid)        dsr <= wr_data;
      else if (adv && (st == ST_DATA))  dsr <= {dsr[WORD_W-2:0], 1'b0};
    end
  end

  serdisp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample  (sample),
    .din     (ser_din),
    .word_end(word_end),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  always_comb begin
    req_ready = (st == ST_IDLE);
    busy      = (st != ST_IDLE);
    ser_csn   = (st == ST_IDLE);
    ser_clk   = ph && ((st == ST_HDR) || (st == ST_DATA));
    ser_doe   = (st != ST_IDLE) && !((st == ST_DATA) && is_rd);
    if (st == ST_HDR)                 ser_dout = hsr[HDR_MAX-1];
    else if (st == ST_DATA && !is_rd) ser_dout = dsr[WORD_W-1];
    else                              ser_dout = 1'b0;
    case (mode_q)
      WIRE5_CS:  ser_rs = rs_q && (st != ST_IDLE);
      WIRE5_CLK: ser_rs = rs_q && ((st == ST_DATA) || (st == ST_WAITW));
      default:   ser_rs = 1'b0;
    endcase
  end
endmodule

// File: rtl/serdisp_master_chk.sv
module serdisp_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic wr_ready,
  input logic rd_valid,
  input logic busy,
  input logic ser_csn,
  input logic ser_clk,
  input logic ser_dout,
  input logic ser_doe,
  input logic ser_rs
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_csn |-> (!ser_clk && !ser_doe && !ser_rs && !ser_dout));

  // R2
  ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ser_csn && !busy));

  // R2
  lead_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_csn) |-> !ser_clk);

  // R3
  dout_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_dout));

  // R8
  wr_take_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !ser_csn);

  // R9
  rd_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(ser_clk) && !ser_clk && !ser_csn));
endmodule

bind serdisp_master serdisp_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .wr_ready (wr_ready),
  .rd_valid (rd_valid),
  .busy     (busy),
  .ser_csn  (ser_csn),
  .ser_clk  (ser_clk),
  .ser_dout (ser_dout),
  .ser_doe  (ser_doe),
  .ser_rs   (ser_rs)
);

// File: tb/serdisp_master_test.sv
`timescale 1ns/1ps
module serdisp_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [7:0]  cfg_half_div = 8'd1;
  logic [4:0]  cfg_pre_len = 5'd0;
  logic [15:0] cfg_pre_bits = 16'h0;
  logic        cfg_rs_first = 1'b0;
  logic        cfg_rw_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_read = 1'b0;
  logic        req_rs = 1'b0;
  logic [3:0]  req_len = 4'd0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = 8'h0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        busy, ser_csn, ser_clk, ser_dout, ser_doe, ser_rs;
  logic        ser_din = 1'b0;

  always #2.5 clk = ~clk;

  serdisp_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_half_div(cfg_half_div),
    .cfg_pre_len(cfg_pre_len), .cfg_pre_bits(cfg_pre_bits), .cfg_rs_first(cfg_rs_first),
    .cfg_rw_en(cfg_rw_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_rs(req_rs), .req_len(req_len), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .ser_csn(ser_csn), .ser_clk(ser_clk), .ser_dout(ser_dout),
    .ser_doe(ser_doe), .ser_din(ser_din), .ser_rs(ser_rs)
  );

  typedef struct {
    bit       csn;
    bit       sck;
    bit       dout;
    bit       doe;
    bit       rs;
    bit       rdv;
    bit       din;
    bit [7:0] rdd;
    int       kind;
  } cyc_t;

  cyc_t     expq[$];
  bit [7:0] wq[$];
  bit       wr_pend = 0;
  int       checks = 0;
  int       failures = 0;
  bit       finished = 0;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endfunction

  function automatic string dtag(int kind);
    case (kind)
      -1: return "R1";
      1:  return "R4";
      2:  return "R5";
      3:  return "R6";
      4:  return "R8";
      5:  return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic cyc();
    cyc_t e;
    @(negedge clk);
    if (wr_pend) begin
      void'(wq.pop_front());
      wr_pend = 0;
    end
    if (expq.size() > 0) e = expq.pop_front();
    else begin
      e = '{csn:1, sck:0, dout:0, doe:0, rs:0, rdv:0, din:0, rdd:8'h0, kind:-1};
    end
    begin
      string g;
      g = (e.kind == -1) ? "R1" : "R2";
      chk(ser_csn == e.csn, g, "ser_csn", ser_csn, e.csn);
      chk(busy == !e.csn, g, "busy", busy, !e.csn);
      chk(req_ready == e.csn, g, "req_ready", req_ready, e.csn);
      chk(ser_clk == e.sck, (e.kind == -1) ? "R1" : "R3", "ser_clk", ser_clk, e.sck);
      chk(ser_dout == e.dout, dtag(e.kind), "ser_dout", ser_dout, e.dout);
      chk(ser_doe == e.doe, (e.kind == -1) ? "R1" : (e.kind == 5) ? "R9" : "R10",
          "ser_doe", ser_doe, e.doe);
      chk(ser_rs == e.rs, (e.kind == -1) ? "R1" : "R7", "ser_rs", ser_rs, e.rs);
      chk(rd_valid == e.rdv, "R9", "rd_valid", rd_valid, e.rdv);
      if (e.rdv) chk(rd_data == e.rdd, "R9", "rd_data", rd_data, e.rdd);
    end
    ser_din = e.din;
    wr_valid = (wq.size() > 0);
    wr_data  = (wq.size() > 0) ? wq[0] : 8'h0;
    wr_pend  = wr_valid && wr_ready;
  endtask

  task automatic frame(int mode, int hdiv, int plen_in, bit [15:0] pbits, bit rsf, bit rwe,
                       bit rd, bit rs, int len, bit [7:0] words[$]);
    bit  bits[$];
    int  kinds[$];
    int  h, plen, hdr_n, nb, halves;
    bit  five;
    cyc_t e;
    h = (hdiv == 0) ? 1 : hdiv;
    plen = (plen_in > 16) ? 16 : plen_in;
    five = (mode >= 2);
    for (int i = plen - 1; i >= 0; i--) begin bits.push_back(pbits[i]); kinds.push_back(1); end
    if (!five) begin
      if (rwe) begin
        if (rsf) begin bits.push_back(rs); bits.push_back(rd); end
        else     begin bits.push_back(rd); bits.push_back(rs); end
        kinds.push_back(2); kinds.push_back(2);
      end else begin
        bits.push_back(rs); kinds.push_back(2);
      end
    end else if (rwe) begin
      bits.push_back(rd); kinds.push_back(3);
    end
    hdr_n = bits.size();
    for (int w = 0; w <= len; w++)
      for (int j = 7; j >= 0; j--) begin
        bits.push_back(words[w][j]);
        kinds.push_back(rd ? 5 : 4);
      end
    nb = bits.size();
    halves = 4 + 2 * nb;
    for (int k = 0; k < halves; k++) begin
      for (int c = 0; c < h; c++) begin
        bit inbit;
        int b;
        inbit = (k >= 2) && (k < 2 + 2 * nb);
        b = inbit ? (k - 2) / 2 : 0;
        e.csn  = 0;
        e.sck  = inbit && (k % 2 == 1);
        e.kind = inbit ? kinds[b] : 0;
        e.dout = inbit && (kinds[b] != 5) ? bits[b] : 1'b0;
        e.doe  = !(inbit && kinds[b] == 5);
        e.din  = inbit && (kinds[b] == 5) ? bits[b] : 1'b0;
        e.rs   = (mode == 3) ? rs : (mode == 2) ? (inbit && b >= hdr_n && rs) : 1'b0;
        e.rdv  = 0;
        e.rdd  = 8'h0;
        expq.push_back(e);
      end
    end
    if (rd)
      for (int w = 0; w <= len; w++) begin
        int idx;
        idx = (4 + 2 * (hdr_n + 8 * w + 7)) * h;
        expq[idx].rdv = 1;
        expq[idx].rdd = words[w];
      end
    cfg_mode = 2'(mode); cfg_half_div = 8'(hdiv); cfg_pre_len = 5'(plen_in);
    cfg_pre_bits = pbits; cfg_rs_first = rsf; cfg_rw_en = rwe;
    req_read = rd; req_rs = rs; req_len = 4'(len);
    if (!rd) begin
      for (int w = 0; w <= len; w++) wq.push_back(words[w]);
      wr_valid = 1; wr_data = wq[0];
    end
    chk(req_ready == 1'b1, "R2", "req_ready before request", req_ready, 1);
    req_valid = 1;
    cyc();
    req_valid = 0;
    while (expq.size() > 0) cyc();
    repeat (3) cyc();
    chk(wq.size() == 0, "R8", "write words left", wq.size(), 0);
  endtask

  initial begin
    bit [7:0] ws[$];
    repeat (4) cyc();
    rst_n = 1;
    repeat (3) cyc();
    // R1 explicit idle state after reset
    chk(ser_csn && !busy && req_ready && !ser_clk, "R1", "idle after reset",
        {ser_csn, busy, req_ready, ser_clk}, 4'b1010);
    // R5 R8: 4-wire single write, RW then RS, no preamble
    ws = '{8'hA6};
    frame(1, 2, 0, 16'h0, 0, 1, 0, 1, 0, ws);
    // R4 R5 R8: 3-wire, 5-bit preamble, RS first, burst of 3
    ws = '{8'h81, 8'h3C, 8'hF0};
    frame(0, 1, 5, 16'h0015, 1, 1, 0, 0, 2, ws);
    // R4 R5 R9 R10: 3-wire read burst, full preamble, RW omitted
    ws = '{8'h5A, 8'hC3};
    frame(0, 3, 16, 16'hA5C3, 0, 0, 1, 1, 1, ws);
    // R6 R7 R9: 5-wire clock-sampled RS, read one word
    ws = '{8'h96};
    frame(2, 1, 3, 16'h0005, 0, 1, 1, 1, 0, ws);
    // R6 R7 R8: 5-wire select-sampled RS, no header at all, write burst
    ws = '{8'h7E, 8'h01};
    frame(3, 2, 0, 16'h0, 0, 0, 0, 1, 1, ws);
    // R3 R4 R6 R7: divider 0 acts as 1, preamble length clamped to 16
    ws = '{8'hE4};
    frame(2, 0, 20, 16'h9C31, 0, 0, 0, 1, 0, ws);
    // R5 R9: 4-wire read burst, RS first with RW present
    ws = '{8'hFF, 8'h00, 8'h6D};
    frame(1, 2, 2, 16'h0002, 1, 1, 1, 0, 2, ws);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule